// File: doc/BRIEF.md
# Mode-Programmable Delay Synchronizer

This block is the receive side of a mesochronous link: sender and receiver run at the same frequency, but the phase between them is unknown. That phase offset is not arbitrary. It takes one of a small set of values, and the current network operating mode decides which one applies. The analog front end is outside this block. It delivers, every cycle, the incoming word as captured at three sampling points: the main clock edge, one delay step after it, and two delay steps after it. Inside the block each of these appears as a plain data field in a single clock domain.

When software raises the program request, the block enters a calibration window. During this window the sender must transmit an alternating training pattern on lane 0. The block watches lane 0 of all three taps over sixteen cycles. It marks every tap that either looked like a slipped or late copy, or showed a metastable-looking glitch. It then keeps the tap that lies furthest from the marked ones and writes it into the entry of a small register bank selected by the mode captured at the start of the window. A one-cycle done pulse reports the end of the window.

In normal operation the entry for the present mode chooses which tap is forwarded to the output. The output passes through a fixed two-register pipeline, so the latency does not depend on the chosen tap. The output stays marked invalid whenever the present mode has no usable entry, and also during calibration.

Top module: `mode_delay_sync`

## Requirements
- R1: After reset every mode entry holds the invalid code 3, `dout_vld` is 0 for every mode, and `cal_done` is 0.
- R2: While no calibration is running, `prog_en` high at a clock edge starts a calibration and captures `mode` at that edge. While a calibration runs, `prog_en` and changes of `mode` are ignored, and the result is written to the entry of the captured mode only.
- R3: Calibration examines lane 0 of each tap (bit `k*DW` of `tap_smp`) at the 16 clock edges that follow the starting edge. At the 16th of these edges the result is written to the bank, and `cal_done` goes high for exactly one cycle.
- R4: A tap is marked unstable if, at any of the 16 edges, its lane-0 value differs from the majority of the three lane-0 values. It is also marked unstable if, at any edge after the first, its lane-0 value equals its own value at the previous edge.
- R5: Among the taps that are not unstable, the one whose distance to the nearest unstable tap is largest is chosen, with a distance of 3 when no tap is unstable. Ties go first to tap 1 and then to the lower index. So: no unstable tap gives 1; {0} gives 2; {2} gives 0; {1} gives 0; {0,1} gives 2; {1,2} gives 0; {0,2} gives 1.
- R6: If all three taps are unstable, the invalid code 3 is written to the entry, replacing any earlier value.
- R7: Each entry is a 2-bit code: values 0, 1 and 2 select tap 0, 1 or 2, and tap k occupies `tap_smp[k*DW +: DW]`. An entry changes only when a calibration of its own mode completes.
- R8: In normal operation `dout` equals the field of the tap selected by the present mode's entry, with `dout_vld` high, exactly two clock edges after the inputs were applied.
- R9: `dout_vld` is 0 two edges after any cycle in which the present mode's entry was invalid or a calibration was running.
- R10: A change of `mode` is taken up at the next clock edge, so the output follows the new mode's tap two edges after the change with no extra cycle.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_en | input | 1 | Request to start a calibration for the present mode |
| mode | input | MW (2) | Network operating mode; selects the bank entry |
| tap_smp | input | 3*DW (12) | Incoming word as captured at taps 0, 1, 2; tap k at bits k*DW upward |
| cal_done | output | 1 | One-cycle pulse when a calibration result is written |
| dout | output | DW (4) | Synchronized data from the selected tap |
| dout_vld | output | 1 | `dout` carries valid data |

## Verification
The embedded assertions check, on every cycle, the properties that only involve timing. The done pulse lasts a single cycle and comes only at the end of a running window. The window counter never leaves its range. The captured mode stays fixed for the whole window. A bank entry never changes without a write. The output is never marked valid two cycles after a calibration cycle. Which tap is chosen for a given training pattern, the resulting output data and its two-edge latency, and the fact that calibrating one mode leaves the other modes untouched can only be shown by the bench. It does this by calibrating modes with late, glitching and clean taps and then reading the forwarded data back through the normal output.

// File: rtl/mds_pkg.sv
package mds_pkg;

    localparam int NTAP = 3;

    typedef logic [1:0] tap_code_t;

    localparam tap_code_t TAP_INV = 2'd3;

    // Write request from the phase detector to the mode bank
    typedef struct packed {
        logic      en;
        logic [7:0] mode;
        tap_code_t code;
    } bank_wr_t;

    // R5/R6: choose the tap furthest from the unstable ones
    function automatic tap_code_t pick_tap(input logic [NTAP-1:0] bad);
        tap_code_t best;
        int        best_s;
        int        d;
        int        dd;
        int        s;
        best   = TAP_INV;
        best_s = -1;
        for (int t = 0; t < NTAP; t++) begin
            if (!bad[t]) begin
                d = NTAP;
                for (int u = 0; u < NTAP; u++) begin
                    if (bad[u]) begin
                        dd = (t > u) ? (t - u) : (u - t);
                        if (dd < d) d = dd;
                    end
                end
                s = d * 4 + ((t == NTAP / 2) ? 2 : ((t < NTAP / 2) ? 1 : 0));
                if (s > best_s) begin
                    best_s = s;
                    best   = tap_code_t'(t);
                end
            end
        end
        return best;
    endfunction

    function automatic logic majority3(input logic [2:0] v);
        return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
    endfunction

endpackage

// File: rtl/mds_detect.sv
module mds_detect
    import mds_pkg::*;
#(
    parameter int WIN = 16,
    parameter int MW  = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [MW-1:0]   mode,
    input  logic [NTAP-1:0] lane0,
    output logic            busy,
    output logic            done,
    output bank_wr_t        wr
);
    localparam int CW = $clog2(WIN + 1);

    logic [CW-1:0]   cnt;
    logic [NTAP-1:0] bad, bad_nx, prev;
    logic            have_prev;
    logic [MW-1:0]   mode_lat;
    logic            maj;
    logic            last;

    assign last = busy && (cnt == CW'(WIN - 1));

    // R4: majority and toggle checks per tap
    always_comb begin
        maj = majority3(lane0);
        for (int k = 0; k < NTAP; k++) begin
            bad_nx[k] = bad[k] | (lane0[k] != maj) |
                        (have_prev & (lane0[k] == prev[k]));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            done      <= 1'b0;
            cnt       <= '0;
            bad       <= '0;
            prev      <= '0;
            have_prev <= 1'b0;
            mode_lat  <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy      <= 1'b1;
                    cnt       <= '0;
                    bad       <= '0;
                    have_prev <= 1'b0;
                    mode_lat  <= mode;
                end
            end else begin
                bad       <= bad_nx;
                prev      <= lane0;
                have_prev <= 1'b1;
                cnt       <= cnt + 1'b1;
                if (last) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        wr      = '0;
        wr.en   = last;
        wr.mode = 8'(mode_lat);
        wr.code = pick_tap(bad_nx);
    end

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_done_after_window_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) && !busy));
    p_cnt_range_r3: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt < CW'(WIN)));
    p_mode_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(mode_lat));

endmodule

// File: rtl/mds_bank.sv
module mds_bank
    import mds_pkg::*;
#(
    parameter int NMODE = 4,
    parameter int MW    = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  bank_wr_t      wr,
    input  logic [MW-1:0] mode,
    output tap_code_t     code
);
    tap_code_t ent [NMODE];

    for (genvar m = 0; m < NMODE; m++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ent[m] <= TAP_INV;
            end else if (wr.en && (wr.mode == 8'(m))) begin
                ent[m] <= wr.code;
            end
        end

        p_entry_hold_r7: assert property (@(posedge clk) disable iff (rst)
            !(wr.en && (wr.mode == 8'(m))) |=> $stable(ent[m]));
    end

    assign code = ent[mode];

endmodule

// File: rtl/mds_align.sv
module mds_align
    import mds_pkg::*;
#(
    parameter int DW = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NTAP*DW-1:0] smp,
    input  tap_code_t          code,
    input  logic               hold,
    output logic [DW-1:0]      dout,
    output logic               dout_vld
);
    logic [DW-1:0] sel, s1_d;
    logic          s1_v;

    always_comb begin
        sel = '0;
        for (int k = 0; k < NTAP; k++) begin
            if (code == tap_code_t'(k)) sel = smp[k*DW +: DW];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_d     <= '0;
            s1_v     <= 1'b0;
            dout     <= '0;
            dout_vld <= 1'b0;
        end else begin
            s1_d     <= sel;
            s1_v     <= (code != TAP_INV) && !hold;
            dout     <= s1_d;
            dout_vld <= s1_v;
        end
    end

endmodule

// File: rtl/mode_delay_sync.sv
module mode_delay_sync
    import mds_pkg::*;
#(
    parameter int DW    = 4,
    parameter int NMODE = 4,
    parameter int WIN   = 16,
    parameter int MW    = $clog2(NMODE)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               prog_en,
    input  logic [MW-1:0]      mode,
    input  logic [NTAP*DW-1:0] tap_smp,
    output logic               cal_done,
    output logic [DW-1:0]      dout,
    output logic               dout_vld
);
    logic [NTAP-1:0] lane0;
    logic            busy;
    bank_wr_t        wr;
    tap_code_t       code;

    for (genvar k = 0; k < NTAP; k++) begin : g_lane
        assign lane0[k] = tap_smp[k*DW];
    end

    mds_detect #(.WIN(WIN), .MW(MW)) u_det (
        .clk(clk), .rst(rst), .start(prog_en), .mode(mode),
        .lane0(lane0), .busy(busy), .done(cal_done), .wr(wr)
    );

    mds_bank #(.NMODE(NMODE), .MW(MW)) u_bank (
        .clk(clk), .rst(rst), .wr(wr), .mode(mode), .code(code)
    );

    mds_align #(.DW(DW)) u_align (
        .clk(clk), .rst(rst), .smp(tap_smp), .code(code), .hold(busy),
        .dout(dout), .dout_vld(dout_vld)
    );

    p_no_vld_after_cal_r9: assert property (@(posedge clk) disable iff (rst)
        $past(busy, 2) |-> !dout_vld);

endmodule

// File: tb/mode_delay_sync_test.sv
module mode_delay_sync_test;
    localparam int DW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          prog_en = 1'b0;
    logic [1:0]    mode = '0;
    logic [3*DW-1:0] tap_smp = '0;
    logic          cal_done;
    logic [DW-1:0] dout;
    logic          dout_vld;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    mode_delay_sync uut (
        .clk(clk), .rst(rst), .prog_en(prog_en), .mode(mode),
        .tap_smp(tap_smp), .cal_done(cal_done), .dout(dout), .dout_vld(dout_vld)
    );

    // vector: {mode[9:8], spec tap2[7:6], tap1[5:4], tap0[3:2], expected code[1:0]}
    // spec: 0 clean alternating, 1 late (inverted), 2 glitching (repeats values)
    localparam logic [9:0] VEC [5] = '{
        {2'd0, 2'd0, 2'd0, 2'd0, 2'd1},  // R5 none unstable -> tap 1
        {2'd1, 2'd0, 2'd0, 2'd2, 2'd2},  // R4 toggle fault on 0 -> tap 2
        {2'd2, 2'd1, 2'd0, 2'd0, 2'd0},  // R4 majority fault on 2 -> tap 0
        {2'd3, 2'd0, 2'd2, 2'd0, 2'd0},  // R5 tie {1} -> tap 0
        {2'd0, 2'd1, 2'd0, 2'd2, 2'd3}   // R6 all unstable -> invalid, overwrites mode 0
    };

    localparam logic [DW-1:0] DAT [3] = '{4'h3, 4'h7, 4'hB};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic tap_bit(input logic [1:0] spec, input int i);
        case (spec)
            2'd0:    return i[0];
            2'd1:    return ~i[0];
            default: return i[1];
        endcase
    endfunction

    // Runs one calibration; optional disturbance mid-window (R2)
    task automatic calibrate(input logic [1:0] m, input logic [5:0] spec, input bit disturb);
        @(negedge clk);
        prog_en = 1'b1;
        mode    = m;
        tap_smp = '0;
        @(posedge clk);
        @(negedge clk);
        prog_en = 1'b0;
        for (int i = 0; i < 16; i++) begin
            tap_smp = '0;
            for (int k = 0; k < 3; k++) tap_smp[k*DW] = tap_bit(spec[k*2 +: 2], i);
            if (disturb && i == 8) begin
                prog_en = 1'b1;
                mode    = m + 2'd1;
                chk(dout_vld == 1'b0, "R9 busy", dout_vld, 0);
            end
            if (disturb && i == 9) prog_en = 1'b0;
            @(posedge clk);
            @(negedge clk);
            if (i == 14) chk(cal_done == 1'b0, "R3 early", cal_done, 0);
        end
        chk(cal_done == 1'b1, "R3 done", cal_done, 1);
        prog_en = 1'b0;
        mode    = m;
        @(posedge clk);
        @(negedge clk);
        chk(cal_done == 1'b0, "R3 pulse", cal_done, 0);
    endtask

    // Reads back a mode's entry through the data path (R7/R8)
    task automatic readback(input logic [1:0] m, input logic [1:0] exp, input string req);
        @(negedge clk);
        mode = m;
        for (int k = 0; k < 3; k++) tap_smp[k*DW +: DW] = DAT[k];
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        chk(dout_vld == (exp != 2'd3), req, dout_vld, (exp != 2'd3));
        if (exp != 2'd3) chk(dout == DAT[exp], req, dout, DAT[exp]);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(cal_done == 1'b0, "R1 done", cal_done, 0);
        for (int m = 0; m < 4; m++) readback(2'(m), 2'd3, "R1 entry");

        for (int v = 0; v < 5; v++) begin
            calibrate(VEC[v][9:8], VEC[v][7:2], 1'b0);
            readback(VEC[v][9:8], VEC[v][1:0], "R5 pick");
        end
        // R7: other entries unchanged, mode 0 now invalid (R6)
        readback(2'd0, 2'd3, "R6 overwrite");
        readback(2'd1, 2'd2, "R7 keep1");
        readback(2'd2, 2'd0, "R7 keep2");
        readback(2'd3, 2'd0, "R7 keep3");

        // R2: clean calibration of mode 1 with prog_en and mode disturbed
        calibrate(2'd1, 6'b000000, 1'b1);
        readback(2'd1, 2'd1, "R2 captured mode");
        readback(2'd2, 2'd0, "R2 other mode");

        // R8/R10: latency and mode switch
        readback(2'd1, 2'd1, "R8 base");
        @(negedge clk);
        mode = 2'd2;
        tap_smp[DW +: DW] = 4'h5;
        @(posedge clk);
        @(negedge clk);
        chk(dout == DAT[1], "R8 latency hold", dout, DAT[1]);
        @(posedge clk);
        @(negedge clk);
        chk(dout == DAT[0] && dout_vld, "R10 switch", dout, DAT[0]);
        mode = 2'd0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        chk(dout_vld == 1'b0, "R9 invalid mode", dout_vld, 0);

        finish_run();
    end
endmodule